// File: doc/BRIEF.md
# Task Address Relocation Unit

This block sits on the address path between a 32-bit processor core and the memory bus. It relocates each address the core issues for the task that is running. It holds three pieces of state: a task base register, a limit mask and a one-bit translate mode. In task mode the logical address is masked by the limit and the base is then added. In physical mode the address passes through unchanged, so a supervisor can reach every physical location directly.

The mode is kept by a two-state machine:
- `MODE_PHYS`: untranslated. This is the reset state.
- `MODE_TASK`: translated.

Its transitions are:
- `PHYS->TASK`: a status restore (return from interrupt) whose translate bit is 1.
- `TASK->PHYS`: either a trap entry (interrupt or software break) or a status restore whose translate bit is 0.
- `ANY->PHYS`: reset.

A trap entry always wins over a status restore in the same cycle. An exchange strobe swaps the base and limit registers with two accumulator-side values. The displaced values are returned to the core.

Vector fetches are never translated. The physical address is registered, so it appears one clock after the logical address is presented. It is computed from the mode, base and limit in force during that cycle.

Top module: `tru_top`

## Requirements
- R1: After reset, `phys_addr_o`, `xlat_o`, `ret_base_o` and `ret_limit_o` are all 0, and the base register is 0.
- R2: While `xlat_o` is 0, `phys_addr_o` one cycle later equals the logical address that was presented.
- R3: While `xlat_o` is 1 and the access is not a vector fetch, `phys_addr_o` one cycle later equals (logical AND limit) + base, modulo 2^32 with no carry out. For example, base 0x0001_0000 and logical 0x0000_2000 give 0x0001_2000.
- R4: `trap_entry_i` makes `xlat_o` 0 after the edge. The address presented in the next cycle is untranslated.
- R5: An access with `vec_fetch_i` = 1 is passed through untranslated, whatever the mode.
- R6: `rti_i` loads the mode from `rti_tbit_i` (1 = translate, 0 = physical). The address presented in the next cycle already uses the new mode.
- R7: `xchg_i` loads base from `acc_base_i` and limit from `acc_limit_i`. After the edge, `ret_base_o` and `ret_limit_o` hold the previous base and limit. The next address uses the new values, and the mode is not changed.
- R8: The limit mask resets to 0xFFFF_FFFF, so translation in task mode is unbounded until software loads a limit.
- R9: When `xchg_i` and `trap_entry_i` are both high in one cycle, the swap takes effect and the mode becomes physical.
- R10: When `trap_entry_i` and `rti_i` are both high in one cycle, the mode becomes physical whatever the value of `rti_tbit_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| log_addr_i | input | 32 | Logical address from the core |
| vec_fetch_i | input | 1 | Current access is an interrupt or break vector fetch |
| trap_entry_i | input | 1 | Interrupt or break entry strobe |
| rti_i | input | 1 | Status restore strobe |
| rti_tbit_i | input | 1 | Translate bit of the restored status word |
| xchg_i | input | 1 | Exchange strobe |
| acc_base_i | input | 32 | New base value from the accumulator side |
| acc_limit_i | input | 32 | New limit mask from the accumulator side |
| phys_addr_o | output | 32 | Registered physical address |
| xlat_o | output | 1 | Current mode, 1 = translating |
| ret_base_o | output | 32 | Base value displaced by the last exchange |
| ret_limit_o | output | 32 | Limit value displaced by the last exchange |

## Verification
The properties assume that the strobes are sampled as single-cycle pulses synchronous to the clock. They also assume that `rti_tbit_i` is meaningful only alongside `rti_i`. Beyond that, the properties allow any overlap of strobes, because the precedence rules are part of the function being checked. The stimulus drives every input once per cycle, half a period away from the active edge. It then walks base, limit and address patterns, including a base that forces the sum to wrap. It also deliberately fires the colliding strobe pairs.

// File: rtl/tru_pkg.sv
package tru_pkg;
    typedef enum logic {
        MODE_PHYS = 1'b0,
        MODE_TASK = 1'b1
    } tru_mode_e;
endpackage

// File: rtl/tru_mode_fsm.sv
module tru_mode_fsm
    import tru_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic trap_i,
    input  logic rti_i,
    input  logic tbit_i,
    output logic xlat_o
);
    tru_mode_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_PHYS;
        else        state_q <= state_d;
    end

    // next-state logic: trap entry dominates status restore
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_PHYS: begin
                if (!trap_i && rti_i && tbit_i) state_d = MODE_TASK;
            end
            MODE_TASK: begin
                if (trap_i)                    state_d = MODE_PHYS;
                else if (rti_i && !tbit_i)     state_d = MODE_PHYS;
            end
            default: state_d = MODE_PHYS;
        endcase
    end

    // output decode
    always_comb begin
        xlat_o = (state_q == MODE_TASK);
    end
endmodule

// File: rtl/tru_regs.sv
module tru_regs #(
    parameter int AW        = 32,
    parameter bit USE_LIMIT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xchg_i,
    input  logic [AW-1:0] new_base_i,
    input  logic [AW-1:0] new_limit_i,
    output logic [AW-1:0] base_o,
    output logic [AW-1:0] limit_o,
    output logic [AW-1:0] ret_base_o,
    output logic [AW-1:0] ret_limit_o
);
    localparam logic [AW-1:0] ALL_ONES = {AW{1'b1}};

    logic [AW-1:0] base_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q     <= '0;
            ret_base_o <= '0;
        end else if (xchg_i) begin
            base_q     <= new_base_i;
            ret_base_o <= base_q;
        end
    end

    generate
        if (USE_LIMIT) begin : g_limit
            logic [AW-1:0] limit_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    limit_q     <= ALL_ONES;
                    ret_limit_o <= '0;
                end else if (xchg_i) begin
                    limit_q     <= new_limit_i;
                    ret_limit_o <= limit_q;
                end
            end
            assign limit_o = limit_q;
        end else begin : g_nolimit
            assign limit_o     = ALL_ONES;
            assign ret_limit_o = ALL_ONES;
        end
    endgenerate

    assign base_o = base_q;
endmodule

// File: rtl/tru_addr_path.sv
module tru_addr_path #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xlat_i,
    input  logic          vec_i,
    input  logic [AW-1:0] log_addr_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] limit_i,
    output logic [AW-1:0] phys_addr_o
);
    logic [AW-1:0] masked;
    logic [AW-1:0] reloc;
    logic [AW-1:0] next_addr;

    always_comb begin
        masked    = log_addr_i & limit_i;
        reloc     = masked + base_i;
        next_addr = (xlat_i && !vec_i) ? reloc : log_addr_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phys_addr_o <= '0;
        else        phys_addr_o <= next_addr;
    end
endmodule

// File: rtl/tru_top.sv
module tru_top #(
    parameter int AW        = 32,
    parameter bit USE_LIMIT = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] log_addr_i,
    input  logic          vec_fetch_i,
    input  logic          trap_entry_i,
    input  logic          rti_i,
    input  logic          rti_tbit_i,
    input  logic          xchg_i,
    input  logic [AW-1:0] acc_base_i,
    input  logic [AW-1:0] acc_limit_i,
    output logic [AW-1:0] phys_addr_o,
    output logic          xlat_o,
    output logic [AW-1:0] ret_base_o,
    output logic [AW-1:0] ret_limit_o
);
    logic [AW-1:0] base_w;
    logic [AW-1:0] lim_w;

    tru_mode_fsm u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .trap_i (trap_entry_i),
        .rti_i  (rti_i),
        .tbit_i (rti_tbit_i),
        .xlat_o (xlat_o)
    );

    tru_regs #(.AW(AW), .USE_LIMIT(USE_LIMIT)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .xchg_i      (xchg_i),
        .new_base_i  (acc_base_i),
        .new_limit_i (acc_limit_i),
        .base_o      (base_w),
        .limit_o     (lim_w),
        .ret_base_o  (ret_base_o),
        .ret_limit_o (ret_limit_o)
    );

    tru_addr_path #(.AW(AW)) u_path (
        .clk         (clk),
        .rst_n       (rst_n),
        .xlat_i      (xlat_o),
        .vec_i       (vec_fetch_i),
        .log_addr_i  (log_addr_i),
        .base_i      (base_w),
        .limit_i     (lim_w),
        .phys_addr_o (phys_addr_o)
    );
endmodule

// File: rtl/tru_checker.sv
module tru_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] log_addr_i,
    input logic          vec_fetch_i,
    input logic          trap_entry_i,
    input logic          rti_i,
    input logic          rti_tbit_i,
    input logic          xchg_i,
    input logic [AW-1:0] phys_addr_o,
    input logic          xlat_o,
    input logic [AW-1:0] base_w,
    input logic [AW-1:0] lim_w
);
    a_r2_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        !xlat_o |=> phys_addr_o == $past(log_addr_i));

    a_r3_relocate: assert property (@(posedge clk) disable iff (!rst_n)
        (xlat_o && !vec_fetch_i) |=>
            phys_addr_o == (($past(log_addr_i) & $past(lim_w)) + $past(base_w)));

    a_r4_trap_clears: assert property (@(posedge clk) disable iff (!rst_n)
        trap_entry_i |=> !xlat_o);

    a_r5_vector_raw: assert property (@(posedge clk) disable iff (!rst_n)
        vec_fetch_i |=> phys_addr_o == $past(log_addr_i));

    a_r6_restore_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (rti_i && !trap_entry_i) |=> xlat_o == $past(rti_tbit_i));

    a_r7_xchg_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg_i && !trap_entry_i && !rti_i) |=> xlat_o == $past(xlat_o));
endmodule

bind tru_top tru_checker #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .log_addr_i   (log_addr_i),
    .vec_fetch_i  (vec_fetch_i),
    .trap_entry_i (trap_entry_i),
    .rti_i        (rti_i),
    .rti_tbit_i   (rti_tbit_i),
    .xchg_i       (xchg_i),
    .phys_addr_o  (phys_addr_o),
    .xlat_o       (xlat_o),
    .base_w       (base_w),
    .lim_w        (lim_w)
);

// File: tb/tru_top_test.sv
`timescale 1ns/1ps
module tru_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] log_addr_i = '0;
    logic        vec_fetch_i = 1'b0;
    logic        trap_entry_i = 1'b0;
    logic        rti_i = 1'b0;
    logic        rti_tbit_i = 1'b0;
    logic        xchg_i = 1'b0;
    logic [31:0] acc_base_i = '0;
    logic [31:0] acc_limit_i = '0;
    logic [31:0] phys_addr_o;
    logic        xlat_o;
    logic [31:0] ret_base_o;
    logic [31:0] ret_limit_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic        m_flag = 1'b0;
    logic [31:0] m_base = '0;
    logic [31:0] m_lim  = 32'hFFFF_FFFF;
    logic [31:0] m_rb   = '0;
    logic [31:0] m_rl   = '0;

    always #2 clk = ~clk;

    tru_top uut (
        .clk (clk), .rst_n (rst_n), .log_addr_i (log_addr_i),
        .vec_fetch_i (vec_fetch_i), .trap_entry_i (trap_entry_i),
        .rti_i (rti_i), .rti_tbit_i (rti_tbit_i), .xchg_i (xchg_i),
        .acc_base_i (acc_base_i), .acc_limit_i (acc_limit_i),
        .phys_addr_o (phys_addr_o), .xlat_o (xlat_o),
        .ret_base_o (ret_base_o), .ret_limit_o (ret_limit_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic [31:0] la,
                        input logic vec, input logic trap, input logic rti,
                        input logic tb, input logic xc,
                        input logic [31:0] ab, input logic [31:0] al);
        logic [31:0] exp;
        log_addr_i = la; vec_fetch_i = vec; trap_entry_i = trap;
        rti_i = rti; rti_tbit_i = tb; xchg_i = xc;
        acc_base_i = ab; acc_limit_i = al;
        exp = (vec || !m_flag) ? la : ((la & m_lim) + m_base);
        @(posedge clk);
        if (xc) begin
            m_rb = m_base; m_rl = m_lim; m_base = ab; m_lim = al;
        end
        if (trap)      m_flag = 1'b0;
        else if (rti)  m_flag = tb;
        @(negedge clk);
        check(tag, "phys_addr", phys_addr_o, exp);
        check(tag, "mode", {31'b0, xlat_o}, {31'b0, m_flag});
        check(tag, "ret_base", ret_base_o, m_rb);
        check(tag, "ret_limit", ret_limit_o, m_rl);
    endtask

    task automatic go(input string tag, input logic [31:0] la);
        step(tag, la, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] bases [4];
        logic [31:0] lims  [3];
        bases[0] = 32'h0000_0000; bases[1] = 32'h0001_0000;
        bases[2] = 32'h8000_4000; bases[3] = 32'hFFFF_F000;
        lims[0]  = 32'hFFFF_FFFF; lims[1]  = 32'h0000_FFFF;
        lims[2]  = 32'h00F0_0FFF;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", "phys_addr", phys_addr_o, 32'h0);
        check("R1", "mode", {31'b0, xlat_o}, 32'h0);
        check("R1", "ret_base", ret_base_o, 32'h0);
        check("R1", "ret_limit", ret_limit_o, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: pass-through sweep in physical mode
        for (int i = 0; i < 64; i++)
            go("R2", (i * 32'h0404_1011) ^ {i[7:0], 24'h00A5C3});

        // R6: restore with translate bit; same-cycle address still raw
        step("R6", 32'h1234_5678, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0, 32'h0);
        // R8: reset limit is all ones, base zero -> identity in task mode
        go("R8", 32'hFFFF_FFFF);
        go("R8", 32'hDEAD_BEEF);
        // R7/R8: exchange reveals reset limit on ret_limit_o
        step("R8", 32'h0000_0100, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1,
             32'h0001_0000, 32'hFFFF_FFFF);
        // R3: worked example
        go("R3", 32'h0000_2000);
        go("R3", 32'h0000_2100);

        // R3/R7: base x limit x address sweep, exchanging while translating
        for (int b = 0; b < 4; b++) begin
            for (int l = 0; l < 3; l++) begin
                step("R7", 32'h0000_0040, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1,
                     bases[b], lims[l]);
                for (int a = 0; a < 8; a++)
                    go("R3", (a * 32'h2491_1357) + 32'h0000_1FFF);
            end
        end

        // R5: vector fetch in task mode is untranslated
        step("R5", 32'hFFFF_FFFC, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
        step("R5", 32'h0000_FFFA, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0);

        // R4: trap entry, then untranslated
        step("R4", 32'h0000_3000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
        go("R4", 32'h0000_3004);
        step("R5", 32'hFFFF_FFFE, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0);

        // R9: exchange and trap together while translating
        step("R6", 32'h0000_0010, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0, 32'h0);
        step("R9", 32'h0000_0020, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1,
             32'h0002_0000, 32'h0000_0FFF);
        go("R9", 32'h0000_1234);
        step("R6", 32'h0000_0030, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0, 32'h0);
        go("R9", 32'h0000_1234);

        // R10: trap beats restore in same cycle
        step("R10", 32'h0000_0044, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0, 32'h0);
        go("R10", 32'h0000_5555);

        // R6: restore with translate bit clear leaves task mode
        step("R6", 32'h0000_0050, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0, 32'h0);
        go("R6", 32'h0000_0777);
        step("R6", 32'h0000_0060, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0);
        go("R6", 32'h0000_0777);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule